// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Handshake Lines

This block holds the control-line logic that sits beside one parallel port. It watches two asynchronous peripheral lines. The first line is always an interrupt input. The second line can be an interrupt input or a control output. Each input line has its own programmable active edge. An active edge latches a flag in the top two bits of the port's control byte. The flags combine with two enable bits to drive an active-low interrupt request.

When the second line is set up as an output, it can do one of three things. It can produce a one-cycle low strobe each time the processor accesses the port. It can drive a static level taken from the control byte. It can rest high.

The block does not decode registers or carry port data. The surrounding logic supplies three single-cycle strobes: a control-byte write, a data-register read and a port access.

Top module: `hs_ctl_lines`

## Requirements
- R1: After reset the control byte reads 0x00, `irq_n` is 1, `ln2_oe` is 0 and `ln2_out` is 1.
- R2: A control write stores bits 5..0 of `ctl_wdata`. Bits 7 and 6 cannot be written, so writing 0xFF with no flags pending reads back 0x3F.
- R3: Bit 1 selects the active edge of `ln1_in`: 0 means falling and 1 means rising. An active edge sets flag bit 7, and the opposite edge has no effect. The flag reads 1 on the third rising clock edge after the line changes, and not on the second.
- R4: With bit 5 = 0, `ln2_in` is an input. Bit 4 selects its active edge (0 = falling, 1 = rising), and an active edge sets flag bit 6.
- R5: With bit 5 = 1, `ln2_oe` is 1 and edges on `ln2_in` never set bit 6. With bit 5 = 0, `ln2_oe` is 0.
- R6: A `data_rd` cycle clears bits 7 and 6 at the next clock edge. A control write leaves them unchanged.
- R7: If an active edge and `data_rd` fall in the same cycle, the flag ends up set.
- R8: `irq_n` is 0 exactly when (bit 7 AND bit 0) OR (bit 6 AND bit 3 AND NOT bit 5).
- R9: With bits 5..3 = 101, a one-cycle `port_acc` drives `ln2_out` low for exactly the one clock cycle that follows the access. After that it returns high.
- R10: With bits 5..4 = 11, `ln2_out` follows bit 3 as a static level.
- R11: With bits 5..3 = 100, `ln2_out` stays high and accesses produce no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| data_rd | input | 1 | Data register read strobe; clears both flags |
| port_acc | input | 1 | Port access strobe for the output pulse |
| ln1_in | input | 1 | Interrupt-only line, asynchronous |
| ln2_in | input | 1 | Second line, sampled when it is an input |
| ctl_rdata | output | 8 | Control byte: flags in 7..6, settings in 5..0 |
| ln2_out | output | 1 | Second line drive value |
| ln2_oe | output | 1 | Second line output enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume three things about the inputs. `ctl_we`, `data_rd` and `port_acc` are synchronous single-cycle strobes. `ln1_in` and `ln2_in` hold each level long enough for the synchronizer to see it. The lines idle low through reset, so no edge appears when reset is released.

The stimulus respects these assumptions. It changes every input only on the falling clock edge. It holds each line level for at least three cycles. It places the clear strobe on the exact cycle in which an edge is detected only to test the set-over-clear case.

// File: rtl/hs_ctl_pkg.sv
package hs_ctl_pkg;
  localparam int CTL_W     = 8;
  localparam int CFG_W     = 6;
  localparam int FLAG1_BIT = 7;
  localparam int FLAG2_BIT = 6;

  typedef struct packed {
    logic l2_output;   // bit 5
    logic l2_ctl4;     // bit 4: polarity (input) or static select (output)
    logic l2_ctl3;     // bit 3: enable (input) or level/pulse select (output)
    logic sel_aux;     // bit 2: stored only, used by register decode
    logic l1_rising;   // bit 1
    logic l1_ie;       // bit 0
  } cfg_t;

  typedef enum logic [1:0] {
    L2_IDLE_HI = 2'd0,
    L2_PULSE   = 2'd1,
    L2_STATIC  = 2'd2
  } l2_mode_e;
endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hs_edge_det.sv
module hs_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    prev_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;
endmodule

// File: rtl/hs_strobe_gen.sv
module hs_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic strobe_lo
);
  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign strobe_lo = pulse_q;
endmodule

// File: rtl/hs_ctl_lines.sv
module hs_ctl_lines
  import hs_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             data_rd,
  input  logic             port_acc,
  input  logic             ln1_in,
  input  logic             ln2_in,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             ln2_out,
  output logic             ln2_oe,
  output logic             irq_n
);
  logic     rst_sync_n;
  cfg_t     cfg_q, cfg_d;
  logic     flag1_q, flag1_d;
  logic     flag2_q, flag2_d;
  logic     rise1, fall1, rise2, fall2;
  logic     hit1, hit2;
  logic     strobe_lo;
  logic     fire;
  l2_mode_e l2_mode;

  hs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  hs_edge_det #(.STAGES(SYNC_STAGES)) u_edge1 (
    .clk(clk), .rst_n(rst_sync_n), .din(ln1_in), .rise(rise1), .fall(fall1)
  );

  hs_edge_det #(.STAGES(SYNC_STAGES)) u_edge2 (
    .clk(clk), .rst_n(rst_sync_n), .din(ln2_in), .rise(rise2), .fall(fall2)
  );

  // Output-mode decode of the second line
  always_comb begin
    if (cfg_q.l2_ctl4)      l2_mode = L2_STATIC;
    else if (cfg_q.l2_ctl3) l2_mode = L2_PULSE;
    else                    l2_mode = L2_IDLE_HI;
  end

  assign fire = port_acc & cfg_q.l2_output & (l2_mode == L2_PULSE);

  hs_strobe_gen u_strobe (
    .clk(clk), .rst_n(rst_sync_n), .fire(fire), .strobe_lo(strobe_lo)
  );

  assign hit1 = cfg_q.l1_rising ? rise1 : fall1;
  assign hit2 = ~cfg_q.l2_output & (cfg_q.l2_ctl4 ? rise2 : fall2);

  // Next state: a detected edge outranks the clearing read
  always_comb begin
    cfg_d   = cfg_q;
    flag1_d = hit1 | (flag1_q & ~data_rd);
    flag2_d = hit2 | (flag2_q & ~data_rd);
    if (ctl_we) cfg_d = cfg_t'(ctl_wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q   <= '0;
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
    end else begin
      if (ctl_we) cfg_q <= cfg_d;
      flag1_q <= flag1_d;
      flag2_q <= flag2_d;
    end
  end

  always_comb begin
    ctl_rdata                = '0;
    ctl_rdata[CFG_W-1:0]     = cfg_q;
    ctl_rdata[FLAG1_BIT]     = flag1_q;
    ctl_rdata[FLAG2_BIT]     = flag2_q;
  end

  always_comb begin
    ln2_out = 1'b1;
    if (cfg_q.l2_output) begin
      unique case (l2_mode)
        L2_STATIC:  ln2_out = cfg_q.l2_ctl3;
        L2_PULSE:   ln2_out = ~strobe_lo;
        default:    ln2_out = 1'b1;
      endcase
    end
  end

  assign ln2_oe = cfg_q.l2_output;
  assign irq_n  = ~((flag1_q & cfg_q.l1_ie) |
                    (flag2_q & cfg_q.l2_ctl3 & ~cfg_q.l2_output));
endmodule

// File: rtl/hs_ctl_lines_chk.sv
module hs_ctl_lines_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       ctl_we,
  input logic       data_rd,
  input logic       port_acc,
  input logic       hit1,
  input logic [7:0] ctl_rdata,
  input logic       ln2_out,
  input logic       irq_n
);
  // R3
  flag1_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ctl_rdata[7]) |-> $past(hit1));

  // R6
  flag1_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!hit1 && !data_rd) |=> $stable(ctl_rdata[7]));

  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_rd && !hit1) |=> !ctl_rdata[7]);

  // R5
  out_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_rdata[5] |=> !$rose(ctl_rdata[6]));

  // R8
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_n |-> (ctl_rdata[0] || ctl_rdata[3]));

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_rdata[5:3] == 3'b101 && !ln2_out && !port_acc && !ctl_we) |=> ln2_out);
endmodule

bind hs_ctl_lines hs_ctl_lines_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .ctl_we(ctl_we), .data_rd(data_rd),
  .port_acc(port_acc), .hit1(hit1), .ctl_rdata(ctl_rdata),
  .ln2_out(ln2_out), .irq_n(irq_n)
);

// File: tb/test_hs_ctl_lines.sv
module test_hs_ctl_lines;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_we, data_rd, port_acc, ln1_in, ln2_in;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_rdata;
  logic       ln2_out, ln2_oe, irq_n;
  int         n_run = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  hs_ctl_lines i_hs_ctl_lines (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .data_rd(data_rd), .port_acc(port_acc), .ln1_in(ln1_in), .ln2_in(ln2_in),
    .ctl_rdata(ctl_rdata), .ln2_out(ln2_out), .ln2_oe(ln2_oe), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    tick(1);
    ctl_we = 1'b0;
  endtask

  task automatic rd_pulse();
    data_rd = 1'b1;
    tick(1);
    data_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctl", ctl_rdata, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    check("R1 oe", {7'd0, ln2_oe}, 8'h00);
    check("R1 out", {7'd0, ln2_out}, 8'h01);
    wcfg(8'hFF);
    check("R2 flags not writable", ctl_rdata, 8'h3F);
    wcfg(8'h00);
    check("R2 rewrite", ctl_rdata, 8'h00);
  endtask

  task automatic t_ln1();
    wcfg(8'h00);
    ln1_in = 1'b1; tick(4);
    check("R3 rising ignored when falling selected", {7'd0, ctl_rdata[7]}, 8'h00);
    ln1_in = 1'b0; tick(2);
    check("R3 not yet after two edges", {7'd0, ctl_rdata[7]}, 8'h00);
    tick(1);
    check("R3 falling sets flag", {7'd0, ctl_rdata[7]}, 8'h01);
    wcfg(8'h02);
    check("R6 write keeps flag", {7'd0, ctl_rdata[7]}, 8'h01);
    rd_pulse();
    check("R6 read clears flag", {7'd0, ctl_rdata[7]}, 8'h00);
    ln1_in = 1'b1; tick(3);
    check("R3 rising sets flag", {7'd0, ctl_rdata[7]}, 8'h01);
    rd_pulse();
    ln1_in = 1'b0; tick(4);
    check("R3 falling ignored when rising selected", {7'd0, ctl_rdata[7]}, 8'h00);
  endtask

  task automatic t_irq1();
    wcfg(8'h00);
    ln1_in = 1'b1; tick(4);
    ln1_in = 1'b0; tick(4);
    check("R8 flag without enable", {7'd0, irq_n}, 8'h01);
    wcfg(8'h01);
    check("R8 bit7 and bit0", {7'd0, irq_n}, 8'h00);
    wcfg(8'h00);
    check("R8 enable dropped", {7'd0, irq_n}, 8'h01);
    rd_pulse();
  endtask

  task automatic t_ln2_in();
    wcfg(8'h00);
    ln2_in = 1'b1; tick(4);
    check("R4 rising ignored", {7'd0, ctl_rdata[6]}, 8'h00);
    ln2_in = 1'b0; tick(3);
    check("R4 falling sets bit6", {7'd0, ctl_rdata[6]}, 8'h01);
    check("R5 oe low in input mode", {7'd0, ln2_oe}, 8'h00);
    check("R8 bit6 without enable", {7'd0, irq_n}, 8'h01);
    wcfg(8'h08);
    check("R8 bit6 and bit3", {7'd0, irq_n}, 8'h00);
    rd_pulse();
    check("R6 read clears bit6", {6'd0, ctl_rdata[7:6]}, 8'h00);
    check("R8 irq released", {7'd0, irq_n}, 8'h01);
    wcfg(8'h10);
    ln2_in = 1'b1; tick(3);
    check("R4 rising sets bit6", {7'd0, ctl_rdata[6]}, 8'h01);
    rd_pulse();
    ln2_in = 1'b0; tick(4);
    check("R4 falling ignored", {7'd0, ctl_rdata[6]}, 8'h00);
  endtask

  task automatic t_ln2_out();
    wcfg(8'h30);
    check("R5 oe high", {7'd0, ln2_oe}, 8'h01);
    check("R10 static low", {7'd0, ln2_out}, 8'h00);
    ln2_in = 1'b1; tick(4);
    ln2_in = 1'b0; tick(4);
    check("R5 edges ignored in output mode", {7'd0, ctl_rdata[6]}, 8'h00);
    wcfg(8'h38);
    check("R10 static high", {7'd0, ln2_out}, 8'h01);
    check("R8 no irq in output mode", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_pulse();
    wcfg(8'h28);
    check("R9 idle high", {7'd0, ln2_out}, 8'h01);
    port_acc = 1'b1; tick(1); port_acc = 1'b0;
    check("R9 low after access", {7'd0, ln2_out}, 8'h00);
    tick(1);
    check("R9 high after one cycle", {7'd0, ln2_out}, 8'h01);
    tick(3);
    check("R9 stays high", {7'd0, ln2_out}, 8'h01);
    wcfg(8'h20);
    port_acc = 1'b1; tick(1); port_acc = 1'b0;
    check("R11 no strobe", {7'd0, ln2_out}, 8'h01);
    tick(1);
    check("R11 still high", {7'd0, ln2_out}, 8'h01);
  endtask

  task automatic t_set_wins();
    wcfg(8'h00);
    ln1_in = 1'b1; tick(4);
    ln1_in = 1'b0; tick(2);
    data_rd = 1'b1; tick(1); data_rd = 1'b0;
    check("R7 set wins over clear", {7'd0, ctl_rdata[7]}, 8'h01);
    rd_pulse();
    check("R6 later read clears", {7'd0, ctl_rdata[7]}, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; data_rd = 1'b0;
    port_acc = 1'b0; ln1_in = 1'b0; ln2_in = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_ln1();
    t_irq1();
    t_ln2_in();
    t_ln2_out();
    t_pulse();
    t_set_wins();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule